// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 interrupt request lines into two processor-facing outputs. One is a normal request and one is a critical request. Each line is set up on its own as level or edge sensitive. Software can also set status bits directly. An enable mask gates which pending sources count at all. A per-source critical select then sends each enabled pending source to one output or the other.

The registers sit on a simple word-addressed register bus. They occupy nine consecutive words starting at a parameterised base address. Reads are combinational and writes take effect on the clock edge.

When the vectoring option is built in, the block computes a vector address for the winning pending critical source. The vector is a software-programmed base plus a fixed stride of 512 times the position of that source. A configuration bit chooses whether the scan starts from the bottom or the top of the status word.

Top module: `vec_intc`

## Requirements
- R1: Only addresses BASE_ADDR+0 to BASE_ADDR+8 are decoded. At these offsets: 0 is status, 1 is status-set, 2 is enable, 3 is critical select, 4 is polarity (stored only), 5 is trigger mode, 6 is masked status, 7 is vector, and 8 is vector configuration. Enable, critical, polarity and trigger read back what was written. Reads elsewhere return 0, and writes elsewhere change nothing.
- R2: Request line n drives status bit 31-n, so line 0 is the most significant status bit.
- R3: A line whose trigger bit is 0 is level sensitive. A rising input sets its status bit and a falling input clears it, one clock after the change.
- R4: A line whose trigger bit is 1 is edge sensitive. A rising input sets its status bit. A low input, or an input held high, never sets or clears the bit; only a clear write can drop it.
- R5: A write to offset 0 clears every status bit written as 1. Any status bit whose level-sensitive line is still high is set again in the same cycle.
- R6: A write to offset 1 sets every status bit written as 1 and leaves the others unchanged.
- R7: The normal output is high exactly when status AND enable AND NOT critical is nonzero. The critical output is high exactly when status AND enable AND critical is nonzero.
- R8: Reading offset 6 returns status AND enable. Offset 0 and offset 1 both read status. Writes to offsets 6 and 7 change nothing.
- R9: With vector configuration bit 0 clear, the vector is (configuration AND 0xFFFFFFFC) + 512 × i. Here i is the lowest set bit index of status AND enable AND critical.
- R10: With vector configuration bit 0 set, the vector is (configuration AND 0xFFFFFFFC) + 512 × (31 − i). Here i is the highest set bit index of status AND enable AND critical.
- R11: The vector reads 0 when no critical source is pending. A write to the vector configuration stores the value with bit 1 forced to 0.
- R12: When built without vectoring (HAS_VECTOR = 0), offsets 7 and 8 always read 0.
- R13: After reset, all nine offsets read 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines; line n maps to status bit 31-n |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and registers |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
Four properties are checked on every cycle:
- edge-mode status bits never drop unless a clear write occurs;
- no active level record is missing from status;
- set and clear writes take effect in the following cycle;
- each output implies a pending enabled source, and the vector is zero when no critical source is pending.

Some behaviours can only be shown by the bench's scenarios:
- the exact address decode and the write masking;
- the reversed line-to-bit mapping;
- the fact that an edge line held high does not re-arm after a clear;
- the exact vector values in both scan directions;
- the reads of a build without vectoring.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = $clog2(WORD_W);

  typedef enum logic [3:0] {
    OFS_STAT  = 4'd0,
    OFS_SET   = 4'd1,
    OFS_ENA   = 4'd2,
    OFS_CRIT  = 4'd3,
    OFS_POL   = 4'd4,
    OFS_TRIG  = 4'd5,
    OFS_MSTAT = 4'd6,
    OFS_VEC   = 4'd7,
    OFS_VCFG  = 4'd8
  } reg_ofs_e;

  // Line n lands on status bit WORD_W-1-n.
  function automatic logic [WORD_W-1:0] line_to_status(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < int'(WORD_W); i++) r[i] = v[WORD_W-1-i];
    return r;
  endfunction

  // Scan position of the winning pending bit; zero when nothing pends.
  function automatic logic [IDX_W-1:0] vec_slot(input logic [WORD_W-1:0] pend,
                                                input logic downward);
    logic [IDX_W-1:0] slot;
    slot = '0;
    if (downward) begin
      for (int i = 0; i < int'(WORD_W); i++)
        if (pend[i]) slot = IDX_W'(WORD_W - 1 - i);
    end else begin
      for (int i = int'(WORD_W) - 1; i >= 0; i--)
        if (pend[i]) slot = IDX_W'(i);
    end
    return slot;
  endfunction

  function automatic logic [WORD_W-1:0] vec_address(input logic [WORD_W-1:0] cfg,
                                                    input logic [WORD_W-1:0] pend,
                                                    input int unsigned stride_shift);
    logic [WORD_W-1:0] step;
    step = WORD_W'(vec_slot(pend, cfg[0])) << stride_shift;
    return (cfg & ~WORD_W'(3)) + step;
  endfunction
endpackage

// File: rtl/vic_input_stage.sv
module vic_input_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] src_q;

  for (genvar g = 0; g < int'(W); g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q[g] <= 1'b0;
      else        src_q[g] <= src_i[g];
    end
    assign rise_o[g] =  src_i[g] & ~src_q[g];
    assign fall_o[g] = ~src_i[g] &  src_q[g];
  end
endmodule

// File: rtl/vic_status.sv
module vic_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_wr,
  input  logic         set_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] trig,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  output logic [W-1:0] status_o,
  output logic [W-1:0] level_o
);
  logic [W-1:0] stat_q, stat_nxt;
  logic [W-1:0] lvl_q, lvl_nxt;
  logic [W-1:0] fall_lvl;
  logic [W-1:0] rise_lvl;

  assign fall_lvl = fall & ~trig;
  assign rise_lvl = rise & ~trig;

  always_comb begin
    stat_nxt = stat_q;
    if (clr_wr)      stat_nxt = (stat_q & ~wdata) | lvl_q;
    else if (set_wr) stat_nxt = stat_q | wdata;
    stat_nxt = (stat_nxt | rise) & ~fall_lvl;
    lvl_nxt  = (lvl_q | rise_lvl) & ~fall_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      lvl_q  <= '0;
    end else begin
      stat_q <= stat_nxt;
      lvl_q  <= lvl_nxt;
    end
  end

  assign status_o = stat_q;
  assign level_o  = lvl_q;

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((($past(stat_q) & $past(trig)) & ~stat_q) == '0));
  // R5
  level_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q & ~stat_q) == '0);
  // R5
  clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && rise == '0) |=> ((stat_q & $past(wdata) & ~$past(lvl_q)) == '0));
  // R6
  set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && fall_lvl == '0) |=> ((stat_q & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/vic_vector.sv
module vic_vector
  import vic_pkg::*;
#(
  parameter bit          HAS_VECTOR = 1'b1,
  parameter int unsigned VEC_SHIFT  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] crit_pend,
  output logic [WORD_W-1:0] vcfg_o,
  output logic [WORD_W-1:0] vector_o
);
  logic any_crit;
  assign any_crit = |crit_pend;

  if (HAS_VECTOR) begin : g_vec
    logic [WORD_W-1:0] vcfg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vcfg_q <= '0;
      else if (cfg_wr) vcfg_q <= wdata & ~WORD_W'(2);
    end
    assign vcfg_o   = vcfg_q;
    assign vector_o = any_crit ? vec_address(vcfg_q, crit_pend, VEC_SHIFT) : '0;
  end else begin : g_novec
    assign vcfg_o   = '0;
    assign vector_o = '0;
  end

  // R11
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_crit |-> (vector_o == '0));
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
#(
  parameter int unsigned          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]    BASE_ADDR  = 8'h40,
  parameter bit                   HAS_VECTOR = 1'b1,
  parameter int unsigned          VEC_SHIFT  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] irq_in,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq_norm_o,
  output logic              irq_crit_o
);
  localparam int unsigned       NUM_REGS  = 9;
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(NUM_REGS - 1);

  logic              hit;
  logic [ADDR_W-1:0] ofs_full;
  reg_ofs_e          ofs;
  logic              wr_hit;

  assign hit      = (bus_addr >= BASE_ADDR) && (bus_addr <= LAST_ADDR);
  assign ofs_full = bus_addr - BASE_ADDR;
  assign ofs      = reg_ofs_e'(ofs_full[3:0]);
  assign wr_hit   = bus_sel && bus_we && hit;

  logic [WORD_W-1:0] ena_q, crit_q, pol_q, trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (wr_hit) begin
      case (ofs)
        OFS_ENA:  ena_q  <= bus_wdata;
        OFS_CRIT: crit_q <= bus_wdata;
        OFS_POL:  pol_q  <= bus_wdata;
        OFS_TRIG: trig_q <= bus_wdata;
        default:  ;
      endcase
    end
  end

  logic [WORD_W-1:0] src_bits, rise, fall;
  assign src_bits = line_to_status(irq_in);

  vic_input_stage #(.W(WORD_W)) u_inp (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_bits),
    .rise_o (rise),
    .fall_o (fall)
  );

  logic [WORD_W-1:0] status, level;
  logic              clr_wr, set_wr, vcfg_wr;
  assign clr_wr  = wr_hit && (ofs == OFS_STAT);
  assign set_wr  = wr_hit && (ofs == OFS_SET);
  assign vcfg_wr = wr_hit && (ofs == OFS_VCFG);

  vic_status #(.W(WORD_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_wr   (clr_wr),
    .set_wr   (set_wr),
    .wdata    (bus_wdata),
    .trig     (trig_q),
    .rise     (rise),
    .fall     (fall),
    .status_o (status),
    .level_o  (level)
  );

  logic [WORD_W-1:0] masked, norm_pend, crit_pend, vcfg, vector;
  assign masked    = status & ena_q;
  assign norm_pend = masked & ~crit_q;
  assign crit_pend = masked & crit_q;

  vic_vector #(.HAS_VECTOR(HAS_VECTOR), .VEC_SHIFT(VEC_SHIFT)) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (vcfg_wr),
    .wdata     (bus_wdata),
    .crit_pend (crit_pend),
    .vcfg_o    (vcfg),
    .vector_o  (vector)
  );

  assign irq_norm_o = |norm_pend;
  assign irq_crit_o = |crit_pend;

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (ofs)
        OFS_STAT, OFS_SET: bus_rdata = status;
        OFS_ENA:           bus_rdata = ena_q;
        OFS_CRIT:          bus_rdata = crit_q;
        OFS_POL:           bus_rdata = pol_q;
        OFS_TRIG:          bus_rdata = trig_q;
        OFS_MSTAT:         bus_rdata = masked;
        OFS_VEC:           bus_rdata = vector;
        OFS_VCFG:          bus_rdata = vcfg;
        default:           bus_rdata = '0;
      endcase
    end
  end

  // R7
  crit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit_o |-> ((status & ena_q) != '0));
  // R7
  norm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm_o |-> ((status & ~crit_q) != '0));
endmodule

// File: tb/vec_intc_bench.sv
`timescale 1ns/1ps
module vec_intc_bench;
  localparam logic [7:0] BASE = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_nv;
  logic        irq_norm, irq_crit, norm_nv, crit_nv;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  vec_intc #(.BASE_ADDR(BASE)) u_vec_intc (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .irq_norm_o(irq_norm), .irq_crit_o(irq_crit));

  vec_intc #(.BASE_ADDR(BASE), .HAS_VECTOR(1'b0)) u_vec_intc_nv (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_nv),
    .irq_norm_o(norm_nv), .irq_crit_o(crit_nv));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = rdata;
    bus_sel = 1'b0;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  // Independent restatement of the vector rule.
  function automatic logic [31:0] exp_vec(input logic [31:0] cfg, input logic [31:0] pend);
    int k;
    if (pend == 0) return 32'h0;
    if (!cfg[0]) begin
      k = 0;
      while (!pend[k]) k++;
      return {cfg[31:2], 2'b00} + k * 512;
    end
    k = 31;
    while (!pend[k]) k--;
    return {cfg[31:2], 2'b00} + (31 - k) * 512;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 9; i++) begin
      rd(BASE + 8'(i), d);
      chk("R13 reset read", d, 32'h0);
    end
    chk("R13 normal out", {31'b0, irq_norm}, 32'h0);
    chk("R13 critical out", {31'b0, irq_crit}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(BASE + 2, 32'hA5A5_0F0F); rd(BASE + 2, d); chk("R1 enable", d, 32'hA5A5_0F0F);
    wr(BASE + 3, 32'h1234_5678); rd(BASE + 3, d); chk("R1 critical", d, 32'h1234_5678);
    wr(BASE + 4, 32'hDEAD_BEEF); rd(BASE + 4, d); chk("R1 polarity", d, 32'hDEAD_BEEF);
    wr(BASE + 5, 32'h0F0F_F0F0); rd(BASE + 5, d); chk("R1 trigger", d, 32'h0F0F_F0F0);
    wr(BASE + 8, 32'hFFFF_FFFF); rd(BASE + 8, d); chk("R11 vcfg bit1", d, 32'hFFFF_FFFD);
    wr(BASE + 9, 32'hFFFF_FFFF); wr(BASE - 1, 32'hFFFF_FFFF);
    rd(BASE + 9, d); chk("R1 undecoded read", d, 32'h0);
    rd(BASE + 2, d); chk("R1 stray write enable", d, 32'hA5A5_0F0F);
    rd(BASE + 0, d); chk("R1 stray write status", d, 32'h0);
    for (int i = 2; i < 6; i++) wr(BASE + 8'(i), 32'h0);
    wr(BASE + 8, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(BASE + 2, 32'hFFFF_FFFF);
    drive(32'h0000_0008);
    rd(BASE + 0, d); chk("R2 R3 line3 to bit28", d, 32'h1000_0000);
    chk("R7 normal high", {31'b0, irq_norm}, 32'h1);
    wr(BASE + 0, 32'hFFFF_FFFF);
    rd(BASE + 0, d); chk("R5 level survives clear", d, 32'h1000_0000);
    drive(32'h0);
    rd(BASE + 0, d); chk("R3 level falls", d, 32'h0);
    chk("R7 normal low", {31'b0, irq_norm}, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(BASE + 5, 32'hFFFF_FFFF);
    drive(32'h0000_0001);
    rd(BASE + 0, d); chk("R2 R4 line0 to bit31", d, 32'h8000_0000);
    wr(BASE + 0, 32'h8000_0000);
    rd(BASE + 0, d); chk("R4 held high no rearm", d, 32'h0);
    drive(32'h0000_0020);
    drive(32'h0);
    rd(BASE + 0, d); chk("R4 edge bit latched", d, 32'h0400_0000);
    wr(BASE + 0, 32'hFFFF_FFFF);
    rd(BASE + 0, d); chk("R5 edge bit cleared", d, 32'h0);
  endtask

  task automatic t_set_mask;
    logic [31:0] d;
    wr(BASE + 2, 32'h0000_0010);
    wr(BASE + 1, 32'h0000_0011);
    rd(BASE + 1, d); chk("R6 set alias", d, 32'h0000_0011);
    wr(BASE + 1, 32'h0000_0100);
    rd(BASE + 0, d); chk("R6 set keeps others", d, 32'h0000_0111);
    rd(BASE + 6, d); chk("R8 masked status", d, 32'h0000_0010);
    wr(BASE + 6, 32'hFFFF_FFFF); wr(BASE + 7, 32'hFFFF_FFFF);
    rd(BASE + 0, d); chk("R8 writes 6 7 ignored", d, 32'h0000_0111);
    wr(BASE + 3, 32'h0000_0010);
    wr(BASE + 2, 32'h0000_0011);
    chk("R7 normal with mix", {31'b0, irq_norm}, 32'h1);
    chk("R7 critical with mix", {31'b0, irq_crit}, 32'h1);
    wr(BASE + 0, 32'h0000_0001);
    chk("R7 normal after clear", {31'b0, irq_norm}, 32'h0);
    chk("R7 critical stays", {31'b0, irq_crit}, 32'h1);
    wr(BASE + 0, 32'hFFFF_FFFF);
  endtask

  task automatic t_vector;
    logic [31:0] d;
    wr(BASE + 2, 32'hFFFF_FFFF);
    wr(BASE + 3, 32'hFFFF_FFFF);
    wr(BASE + 8, 32'h0001_0000);
    rd(BASE + 7, d); chk("R11 vector idle", d, 32'h0);
    wr(BASE + 1, 32'h0010_0010);
    rd(BASE + 7, d); chk("R9 ascending", d, exp_vec(32'h0001_0000, 32'h0010_0010));
    chk("R9 ascending value", d, 32'h0001_0800);
    wr(BASE + 8, 32'h0001_0003);
    rd(BASE + 8, d); chk("R11 vcfg stored", d, 32'h0001_0001);
    rd(BASE + 7, d); chk("R10 descending", d, exp_vec(32'h0001_0001, 32'h0010_0010));
    chk("R10 descending value", d, 32'h0001_1600);
    wr(BASE + 0, 32'hFFFF_FFFF);
    rd(BASE + 7, d); chk("R11 vector cleared", d, 32'h0);
    chk("R7 critical low", {31'b0, irq_crit}, 32'h0);
  endtask

  task automatic t_novec;
    wr(BASE + 8, 32'h1234_5678);
    wr(BASE + 1, 32'h0000_0001);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b0; bus_addr = BASE + 8;
    #1 chk("R12 vcfg reads zero", rdata_nv, 32'h0);
    bus_addr = BASE + 7;
    #1 chk("R12 vector reads zero", rdata_nv, 32'h0);
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level();
    t_edge();
    t_set_mask();
    t_vector();
    t_novec();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule